// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A memory-mapped watchdog timer for a system that must recover from hung software. A 16-bit down-counter is clocked by a tick that comes from two division stages in series. The first stage is an 8-bit programmable prescaler that divides the clock by P+1. The second stage is a fixed divider that divides by 16, 32, 64 or 128. When the counter expires, the block can set a pending interrupt, emit a one-cycle system reset request, or both, depending on two enable bits. It then reloads from a reload register and keeps running.

Software keeps the system alive by writing the count register before expiry. That write loads the live counter at once and restarts the division chain. A pending interrupt is cleared by writing any value to a write-only clear register. A debug-acknowledge input can hold both outputs low while a debugger has the system stopped, provided the debug-mask control bit is set. The register port takes single-cycle requests and returns read data one cycle later.

Top module: `prescaled_wdt`

## Requirements
- R1: After reset the control register reads 0x0000_8000 (prescaler 0x80, everything else off), the reload and count registers read 0x8000, and `irq_o` and `sys_rst_req_o` are 0.
- R2: The register word index is `req_addr[3:2]`: 0 is control, 1 is reload, 2 is count and 3 is interrupt clear. Control holds reset-enable at bit 0, interrupt-enable at bit 2, divider select at [4:3], counter-enable at bit 5, prescaler P at [15:8] and debug mask at bit 16. All other control bits read 0, so writing all ones reads back 0x0001_FF3D. Reload and count keep bits [15:0].
- R3: With the counter enabled, one decrement tick occurs every (P+1)·(16·2^sel) clock cycles. Expiry occurs N ticks after a count write of N ≥ 1, and the outputs show it one cycle after expiry.
- R4: A count write loads the counter on that edge and restarts both division stages. Reading the count register returns the live counter value.
- R5: At expiry the counter reloads from the reload register and keeps running, so a second expiry follows one full period later.
- R6: Expiry sets the interrupt-pending flag only when interrupt-enable is 1. The flag holds until any write to the clear register. `irq_o` follows the flag with one cycle of delay. If an expiry and a clear fall in the same cycle, the flag is set.
- R7: When reset-enable is 1, each expiry drives `sys_rst_req_o` high for exactly one cycle.
- R8: With counter-enable at 0 the counter and both division stages hold, and no expiry occurs.
- R9: While the debug mask bit is 1 and `dbg_ack_i` is 1, both outputs are held at 0. A pending interrupt shows again once `dbg_ack_i` falls.
- R10: A read of the clear register returns 0 and raises `rsp_err_o` for that response. Reads of the other registers return `rsp_err_o` = 0.
- R11: A tick that finds the counter at 0 counts as an expiry and reloads, so a count write of 0 expires after one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Register access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address; word index in [3:2] |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, one cycle after the request |
| rsp_err_o | output | 1 | Error flag for the read response |
| dbg_ack_i | input | 1 | Debug acknowledge from the processor |
| irq_o | output | 1 | Watchdog interrupt (registered) |
| sys_rst_req_o | output | 1 | One-cycle system reset request (registered) |

## Verification
The assertions assume the register port issues at most one request per cycle. They also assume the prescaler value is not lowered below the running prescale count while the counter runs. The stimulus rewrites the control register only with the counter stopped, or together with a count write that restarts the chain. The stimulus also keeps the random prescaler, divider and reload values small, so every expiry period falls well inside the bench's wait limits.

// File: rtl/pwdt_pkg.sv
package pwdt_pkg;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 16;
  localparam int PRE_W     = 8;
  localparam int SEL_W     = 2;
  localparam int BASE_LOG2 = 4;

  // word indices (req_addr[3:2])
  localparam logic [1:0] IDX_CTRL   = 2'd0;
  localparam logic [1:0] IDX_RELOAD = 2'd1;
  localparam logic [1:0] IDX_COUNT  = 2'd2;
  localparam logic [1:0] IDX_CLR    = 2'd3;

  localparam logic [CNT_W-1:0] CNT_INIT = 16'h8000;
  localparam logic [PRE_W-1:0] PRE_INIT = 8'h80;

  typedef struct packed {
    logic             dbg_mask;
    logic [PRE_W-1:0] pre;
    logic             cnt_en;
    logic [SEL_W-1:0] div_sel;
    logic             irq_en;
    logic             rst_en;
  } ctrl_t;
endpackage

// File: rtl/pwdt_regs.sv
module pwdt_regs
  import pwdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  live_count,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic              clr_pend,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  logic       in_range;
  logic [1:0] idx;
  logic       wr, rd;

  generate
    if (ADDR_W > 4) begin : g_upper
      assign in_range = (req_addr[ADDR_W-1:4] == '0);
    end else begin : g_flat
      assign in_range = 1'b1;
    end
  endgenerate

  assign idx = req_addr[3:2];
  assign wr  = req_valid && req_write && in_range;
  assign rd  = req_valid && !req_write && in_range;

  assign cnt_load     = wr && (idx == IDX_COUNT);
  assign cnt_load_val = req_wdata[CNT_W-1:0];
  assign clr_pend     = wr && (idx == IDX_CLR);

  logic unused_bits;
  assign unused_bits = ^{req_wdata[DATA_W-1:17], req_wdata[7:6], req_wdata[1], req_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '{dbg_mask: 1'b0, pre: PRE_INIT, cnt_en: 1'b0, div_sel: '0, irq_en: 1'b0, rst_en: 1'b0};
      reload   <= CNT_INIT;
    end else if (wr) begin
      if (idx == IDX_CTRL) begin
        ctrl.rst_en   <= req_wdata[0];
        ctrl.irq_en   <= req_wdata[2];
        ctrl.div_sel  <= req_wdata[4:3];
        ctrl.cnt_en   <= req_wdata[5];
        ctrl.pre      <= req_wdata[15:8];
        ctrl.dbg_mask <= req_wdata[16];
      end
      if (idx == IDX_RELOAD) reload <= req_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      if (rd) begin
        unique case (idx)
          IDX_CTRL:   rsp_rdata <= {{(DATA_W-17){1'b0}}, ctrl.dbg_mask, ctrl.pre, 2'b00,
                                    ctrl.cnt_en, ctrl.div_sel, ctrl.irq_en, 1'b0, ctrl.rst_en};
          IDX_RELOAD: rsp_rdata <= {{(DATA_W-CNT_W){1'b0}}, reload};
          IDX_COUNT:  rsp_rdata <= {{(DATA_W-CNT_W){1'b0}}, live_count};
          IDX_CLR:    rsp_err   <= 1'b1;
          default:    rsp_rdata <= '0;
        endcase
      end
    end
  end

  // R10: an error response never carries data
  p_err_no_data_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));
endmodule

// File: rtl/pwdt_clkdiv.sv
module pwdt_clkdiv
  import pwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int FW = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pcnt;
  logic [FW-1:0]    fcnt;
  logic [FW-1:0]    lim;
  logic             pwrap;

  always_comb lim = FW'((32'd1 << (32'(BASE_LOG2) + 32'(sel))) - 32'd1);
  assign pwrap = (pcnt == pre);
  assign tick  = run && pwrap && (fcnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pcnt <= '0;
      fcnt <= '0;
    end else if (pwrap) begin
      pcnt <= '0;
      fcnt <= (fcnt == lim) ? '0 : fcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  // R3: smallest period is 16 cycles, so ticks are never back to back
  p_tick_spaced_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pwdt_counter.sv
module pwdt_counter
  import pwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  input  logic             rst_en,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             irq_pend,
  output logic             rst_pulse
);
  logic expire;
  assign expire = tick && !load && (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)         count <= CNT_INIT;
    else if (load)   count <= load_val;
    else if (expire) count <= reload;
    else if (tick)   count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  irq_pend <= 1'b0;
    else if (expire && irq_en) irq_pend <= 1'b1;
    else if (clr)             irq_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rst_pulse <= 1'b0;
    else     rst_pulse <= expire && rst_en;
  end

  // R5 / R11: expiry reloads from the reload register
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && (count <= CNT_W'(1))) |=> (count == $past(reload)));
  // R4: a count write wins over any tick
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/prescaled_wdt.sv
module prescaled_wdt
  import pwdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_err_o,
  input  logic              dbg_ack_i,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, count, load_val;
  logic             cnt_load, clr_pend, tick, irq_pend, rst_pulse, mask;

  pwdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .req_valid(req_valid_i), .req_write(req_write_i),
    .req_addr(req_addr_i), .req_wdata(req_wdata_i),
    .live_count(count), .ctrl(ctrl), .reload(reload),
    .cnt_load(cnt_load), .cnt_load_val(load_val), .clr_pend(clr_pend),
    .rsp_rdata(rsp_rdata_o), .rsp_err(rsp_err_o)
  );

  pwdt_clkdiv u_div (
    .clk(clk), .rst(rst), .run(ctrl.cnt_en), .restart(cnt_load),
    .pre(ctrl.pre), .sel(ctrl.div_sel), .tick(tick)
  );

  pwdt_counter u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_load), .load_val(load_val),
    .reload(reload), .irq_en(ctrl.irq_en), .rst_en(ctrl.rst_en), .clr(clr_pend),
    .count(count), .irq_pend(irq_pend), .rst_pulse(rst_pulse)
  );

  assign mask = ctrl.dbg_mask && dbg_ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o         <= 1'b0;
      sys_rst_req_o <= 1'b0;
    end else begin
      irq_o         <= irq_pend && !mask;
      sys_rst_req_o <= rst_pulse && !mask;
    end
  end

  // R7: reset request is a single-cycle pulse
  p_rst_single_r7: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req_o |=> !sys_rst_req_o);
  // R9: debug mask silences both outputs
  p_dbg_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl.dbg_mask && dbg_ack_i) |=> (!irq_o && !sys_rst_req_o));
  // R8: stopped counter holds unless software loads it
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.cnt_en && !cnt_load) |=> $stable(count));
endmodule

// File: tb/prescaled_wdt_tb.sv
module prescaled_wdt_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err, dbg_ack = 1'b0, irq, sys_rst_req;

  int errors = 0;
  int checks = 0;
  int unsigned cyc = 0;
  bit done = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_RELOAD = 4'h4, A_COUNT = 4'h8, A_CLR = 4'hC;

  prescaled_wdt #(.ADDR_W(4)) u_dut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .dbg_ack_i(dbg_ack), .irq_o(irq), .sys_rst_req_o(sys_rst_req)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [3:0] a, logic [31:0] d, output int unsigned at);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    at = cyc;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic reg_rd(logic [3:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; e = rsp_err;
  endtask

  // which: 0 = irq, 1 = reset request
  task automatic wait_out(bit which, int unsigned limit, output int unsigned at);
    at = 0;
    for (int unsigned i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((which ? sys_rst_req : irq) === 1'b1) begin
        at = cyc;
        break;
      end
    end
  endtask

  function automatic int unsigned period(int unsigned p, int unsigned sel, int unsigned n);
    return n * (p + 1) * (16 << sel);
  endfunction

  function automatic logic [31:0] mk_ctrl(bit rst_en, bit irq_en, int unsigned sel,
                                          bit en, int unsigned p, bit dbg);
    return {15'd0, dbg, p[7:0], 2'b00, en, sel[1:0], irq_en, 1'b0, rst_en};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    int unsigned w, t, t2, tp;
    bit seen;
    void'($urandom(32'h5EED_1234));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rst_req", {31'd0, sys_rst_req}, 0);
    reg_rd(A_CTRL, d, e);   chk("R1 ctrl", d, 32'h0000_8000);
    reg_rd(A_RELOAD, d, e); chk("R1 reload", d, 32'h8000);
    reg_rd(A_COUNT, d, e);  chk("R1 count", d, 32'h8000);
    chk("R10 no err on count read", {31'd0, e}, 0);

    // R2 register layout
    reg_wr(A_CTRL, 32'hFFFF_FFDF, w);  // everything but enable
    reg_rd(A_CTRL, d, e);   chk("R2 ctrl mask", d, 32'h0001_FF1D);
    reg_wr(A_RELOAD, 32'hABCD_5A5A, w);
    reg_rd(A_RELOAD, d, e); chk("R2 reload width", d, 32'h5A5A);
    reg_wr(A_CTRL, 32'h0, w);

    // R10 clear-register read
    reg_rd(A_CLR, d, e);
    chk("R10 clr rdata", d, 0);
    chk("R10 clr err", {31'd0, e}, 1);

    // R4 immediate load, live readback
    reg_wr(A_COUNT, 32'h1234, w);
    reg_rd(A_COUNT, d, e);  chk("R4 count load", d, 32'h1234);

    // R8 stopped counter holds
    repeat (300) @(negedge clk);
    reg_rd(A_COUNT, d, e);  chk("R8 frozen count", d, 32'h1234);
    chk("R8 no irq", {31'd0, irq}, 0);

    // R3 / R5 / R6 random periods
    for (int it = 0; it < 8; it++) begin
      int unsigned p, sel, n;
      p = $urandom % 4; sel = $urandom % 4; n = 1 + $urandom % 4;
      tp = period(p, sel, 1);
      t = period(p, sel, n);
      reg_wr(A_CTRL, mk_ctrl(0, 1, sel, 1, p, 0), w);
      reg_wr(A_RELOAD, n, w);
      reg_wr(A_COUNT, n, w);
      wait_out(0, t + 50, t2);
      chk("R3 expiry time", t2 - w, t + 1);
      if (t > tp) begin
        reg_rd(A_COUNT, d, e);  // counter now near top after reload
        chk("R5 reloaded value", d, n);
      end
      reg_wr(A_CLR, $urandom, tp);
      @(negedge clk);
      chk("R6 cleared", {31'd0, irq}, 0);
      wait_out(0, t + 50, t2);
      chk("R5 second expiry", t2 - w, 2 * t + 1);
      reg_wr(A_CTRL, 32'h0, tp);
      reg_wr(A_CLR, 32'h0, tp);
      @(negedge clk);
    end

    // R7 reset pulse, R6 irq gated by enable
    reg_wr(A_CTRL, mk_ctrl(1, 0, 0, 1, 1, 0), w);
    reg_wr(A_RELOAD, 3, w);
    reg_wr(A_COUNT, 3, w);
    wait_out(1, 200, t2);
    chk("R7 reset time", t2 - w, period(1, 0, 3) + 1);
    @(negedge clk);
    chk("R7 pulse width", {31'd0, sys_rst_req}, 0);
    chk("R6 no irq when disabled", {31'd0, irq}, 0);
    reg_wr(A_CTRL, 32'h0, w);

    // R11 zero count expires after one tick
    reg_wr(A_CTRL, mk_ctrl(0, 1, 1, 1, 0, 0), w);
    reg_wr(A_RELOAD, 5, w);
    reg_wr(A_COUNT, 0, w);
    wait_out(0, 200, t2);
    chk("R11 zero expiry", t2 - w, period(0, 1, 1) + 1);
    reg_wr(A_CTRL, 32'h0, w);
    reg_wr(A_CLR, 32'h0, w);

    // R9 debug mask
    dbg_ack = 1'b1;
    reg_wr(A_CTRL, mk_ctrl(1, 1, 0, 1, 0, 1), w);
    reg_wr(A_RELOAD, 2, w);
    reg_wr(A_COUNT, 2, w);
    seen = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (irq || sys_rst_req) seen = 1;
    end
    chk("R9 outputs masked", {31'd0, seen}, 0);
    dbg_ack = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 irq after unmask", {31'd0, irq}, 1);
    reg_wr(A_CTRL, 32'h0, w);
    reg_wr(A_CLR, 32'h0, w);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule